// File: doc/BRIEF.md
# Descriptor Ring Transmit Scheduler

This block keeps a table of buffer descriptors that the host reads and writes over a simple memory-mapped bus. The table holds two rings. Transmit descriptors sit at the low indices and receive descriptors at the indices above them. A transmit-count register sets where one ring ends and the other begins. Each descriptor has two 32-bit words: a status/control word, then a buffer address.

The engine walks the transmit ring in order. For each descriptor that the host has marked ready, it requests a frame from a transmitter stub and holds the request until the stub signals done. It then writes the completion status back into the same descriptor word, returns the descriptor to the host and moves to the next index.

Frames reported by a receiver stub claim the current receive descriptor if that descriptor is marked empty. If it is not empty, the frame is dropped and a busy source is raised. Interrupt sources are set only for descriptors that ask for them. A mask gates the single interrupt output.

Top module: `desc_ring_sched`

## Requirements
- R1: After reset the mode register (byte 0x00; bit 0 receive enable, bit 1 transmit enable), source register (0x04), mask register (0x08) and `txReq`/`irq` are all zero. The transmit-count register (0x0C) reads the smaller of TX_MAX and DESC_NUM/2.
- R2: Descriptor i has its status word at byte 0x400+8i and its buffer address at 0x404+8i. While transmit is enabled and bit 15 (ready) of the current transmit descriptor is set, `txReq` rises and presents the following fields: length from bits 31:16, pad from bit 12, CRC from bit 11, and the address word. It holds until `txDone`.
- R3: On `txDone` the status word becomes: bits 31:16 and 14:11 kept, bit 15 cleared, bits 10:9 zero, and `txStatus` in bits 8:0.
- R4: A transmit completion whose descriptor has bit 14 set raises source bit 1 if any of `txStatus` bits 0, 1, 2, 3 or 8 is set, and raises source bit 0 otherwise. The retry count in bits 7:4 alone is not an error. With bit 14 clear, no source is raised.
- R5: After a transmit completion the index advances by one. After a descriptor with bit 13 (wrap) set, or after index N-1, it returns to index 0. A ready bit that the host sets later is picked up without any other action.
- R6: While mode bit 1 is clear, no transmit request starts.
- R7: An `rxValid` pulse with receive enabled and bit 15 (empty) of the current receive descriptor set rewrites that word as follows: length in bits 31:16, bit 15 cleared, bits 14:13 kept, bits 12:9 zero, `rxStatus` in bits 8:0. If bit 14 is set, it raises source bit 3 when any of `rxStatus` bits 7:0 is set, and source bit 2 otherwise. Bit 8 (control frame) is not an error.
- R8: Receive descriptors start at index N. After a wrap descriptor, or after the last table entry, the receive index returns to N.
- R9: An `rxValid` pulse that meets a non-empty receive descriptor leaves the table unchanged and raises source bit 4. With receive disabled, `rxValid` changes nothing.
- R10: Writing 1 to a source bit clears it; a new event in the same cycle wins. `irq` is high exactly when a source bit and its mask bit are both set.
- R11: A write to the transmit-count register stores the value clamped to the range 1..TX_MAX. It resets the transmit index to 0 and the receive index to the new N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Host byte address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data (combinational) |
| irq | output | 1 | Masked interrupt |
| txReq | output | 1 | Frame request to transmitter stub |
| txBufAddr | output | 32 | Buffer address of requested frame |
| txLen | output | 16 | Frame length |
| txPad | output | 1 | Pad short frame |
| txCrc | output | 1 | Append CRC |
| txDone | input | 1 | Transmitter finished current frame |
| txStatus | input | 9 | Transmit completion status |
| rxValid | input | 1 | Receiver delivered a frame |
| rxLen | input | 16 | Received length |
| rxStatus | input | 9 | Receive status bits |
| rxBufAddr | output | 32 | Buffer address of current receive descriptor |

## Verification
The bench builds the block with DESC_NUM=16 and TX_MAX=8. The reset split is then 8 transmit and 8 receive descriptors, so both rings, the wrap at the last transmit index and the wrap back to index N are all reached in a few frames. A TX_MAX of 8 puts the clamp within reach: writing 20 to the transmit-count register must read back 8, and writing 0 must read back 1.

// File: rtl/ring_sched_pkg.sv
package ring_sched_pkg;
  // strobes from the sequencing control into the table datapath
  typedef struct packed {
    logic txFinish;  // current transmit descriptor completes
    logic rxClaim;   // incoming frame takes current receive descriptor
    logic rxBusy;    // incoming frame dropped, descriptor not empty
  } engStrobe_t;

  localparam int OWN_BIT  = 15;
  localparam int IRQ_BIT  = 14;
  localparam int WRAP_BIT = 13;
  localparam int PAD_BIT  = 12;
  localparam int CRC_BIT  = 11;

  localparam int SRC_TXOK  = 0;
  localparam int SRC_TXERR = 1;
  localparam int SRC_RXOK  = 2;
  localparam int SRC_RXERR = 3;
  localparam int SRC_BUSY  = 4;
endpackage

// File: rtl/ring_sched_ctrl.sv
module ring_sched_ctrl
  import ring_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       rxEn,
  input  logic       txOwned,
  input  logic       rxOwned,
  input  logic       txDone,
  input  logic       rxValid,
  output logic       txReq,
  output engStrobe_t strb
);
  always_ff @(posedge clk) begin
    if (!rstN) txReq <= 1'b0;
    else if (!txReq) txReq <= txEn && txOwned;
    else if (txDone) txReq <= 1'b0;
  end

  always_comb begin
    strb.txFinish = txReq && txDone;
    strb.rxClaim  = rxValid && rxEn && rxOwned;
    strb.rxBusy   = rxValid && rxEn && !rxOwned;
  end
endmodule

// File: rtl/ring_sched_dp.sv
module ring_sched_dp
  import ring_sched_pkg::*;
#(
  parameter int DESC_NUM = 256,
  parameter int TX_MAX   = 128,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = $clog2(DESC_NUM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  input  engStrobe_t        strb,
  input  logic [8:0]        txStatus,
  input  logic [15:0]       rxLen,
  input  logic [8:0]        rxStatus,
  output logic [31:0]       curTxStat,
  output logic [31:0]       curTxAddr,
  output logic [31:0]       curRxStat,
  output logic [31:0]       curRxAddr,
  output logic              txEn,
  output logic              rxEn,
  output logic [IDX_W-1:0]  txIdx,
  output logic [IDX_W-1:0]  rxIdx,
  output logic [IDX_W-1:0]  txNum,
  output logic [4:0]        intSrc,
  output logic [4:0]        intMask,
  output logic              irq
);
  localparam int DESC_BASE = 'h400;
  localparam int DESC_END  = DESC_BASE + 8 * DESC_NUM;
  localparam int NUM_RST   = (TX_MAX < DESC_NUM / 2) ? TX_MAX : DESC_NUM / 2;

  logic [31:0] statMem [DESC_NUM];
  logic [31:0] addrMem [DESC_NUM];
  logic [1:0]  modeReg;

  logic              isDesc;
  logic [ADDR_W-1:0] descOff;
  logic [IDX_W-1:0]  hostIdx;
  logic [31:0]       txWb, rxWb;
  logic [4:0]        srcSet;
  logic [IDX_W-1:0]  numClamp, txNext, rxNext;
  logic              wrNum;

  assign isDesc  = (int'(hostAddr) >= DESC_BASE) && (int'(hostAddr) < DESC_END);
  assign descOff = hostAddr - ADDR_W'(DESC_BASE);
  assign hostIdx = descOff[IDX_W+2:3];
  assign wrNum   = hostWe && hostAddr == ADDR_W'('h0C);

  assign curTxStat = statMem[txIdx];
  assign curTxAddr = addrMem[txIdx];
  assign curRxStat = statMem[rxIdx];
  assign curRxAddr = addrMem[rxIdx];
  assign txEn = modeReg[1];
  assign rxEn = modeReg[0];
  assign irq  = |(intSrc & intMask);

  always_comb begin
    txWb = {curTxStat[31:16], 1'b0, curTxStat[14:11], 2'b00, txStatus};
    rxWb = {rxLen, 1'b0, curRxStat[14:13], 4'b0000, rxStatus};
    srcSet = '0;
    if (strb.txFinish && curTxStat[IRQ_BIT]) begin
      if (|{txStatus[8], txStatus[3:0]}) srcSet[SRC_TXERR] = 1'b1;
      else srcSet[SRC_TXOK] = 1'b1;
    end
    if (strb.rxClaim && curRxStat[IRQ_BIT]) begin
      if (|rxStatus[7:0]) srcSet[SRC_RXERR] = 1'b1;
      else srcSet[SRC_RXOK] = 1'b1;
    end
    if (strb.rxBusy) srcSet[SRC_BUSY] = 1'b1;

    if (hostWdata == 32'd0) numClamp = IDX_W'(1);
    else if (hostWdata > 32'(TX_MAX)) numClamp = IDX_W'(TX_MAX);
    else numClamp = hostWdata[IDX_W-1:0];

    txNext = (curTxStat[WRAP_BIT] || txIdx == txNum - 1'b1) ? '0 : txIdx + 1'b1;
    rxNext = (curRxStat[WRAP_BIT] || int'(rxIdx) == DESC_NUM - 1) ? txNum : rxIdx + 1'b1;
  end

  // descriptor table: engine write-back lands after the host write
  always_ff @(posedge clk) begin
    if (hostWe && isDesc) begin
      if (hostAddr[2]) addrMem[hostIdx] <= hostWdata;
      else statMem[hostIdx] <= hostWdata;
    end
    if (strb.txFinish) statMem[txIdx] <= txWb;
    if (strb.rxClaim)  statMem[rxIdx] <= rxWb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      intSrc  <= '0;
      intMask <= '0;
      txNum   <= IDX_W'(NUM_RST);
      txIdx   <= '0;
      rxIdx   <= IDX_W'(NUM_RST);
    end else begin
      if (hostWe && hostAddr == ADDR_W'('h00)) modeReg <= hostWdata[1:0];
      if (hostWe && hostAddr == ADDR_W'('h08)) intMask <= hostWdata[4:0];
      if (hostWe && hostAddr == ADDR_W'('h04)) intSrc <= (intSrc & ~hostWdata[4:0]) | srcSet;
      else intSrc <= intSrc | srcSet;
      if (wrNum) begin
        txNum <= numClamp;
        txIdx <= '0;
        rxIdx <= numClamp;
      end else begin
        if (strb.txFinish) txIdx <= txNext;
        if (strb.rxClaim)  rxIdx <= rxNext;
      end
    end
  end

  always_comb begin
    hostRdata = '0;
    if (isDesc) hostRdata = hostAddr[2] ? addrMem[hostIdx] : statMem[hostIdx];
    else begin
      case (hostAddr)
        ADDR_W'('h00): hostRdata = {30'd0, modeReg};
        ADDR_W'('h04): hostRdata = {27'd0, intSrc};
        ADDR_W'('h08): hostRdata = {27'd0, intMask};
        ADDR_W'('h0C): hostRdata = 32'(txNum);
        default:       hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/desc_ring_sched.sv
module desc_ring_sched
  import ring_sched_pkg::*;
#(
  parameter int DESC_NUM = 256,
  parameter int TX_MAX   = 128,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              irq,
  output logic              txReq,
  output logic [31:0]       txBufAddr,
  output logic [15:0]       txLen,
  output logic              txPad,
  output logic              txCrc,
  input  logic              txDone,
  input  logic [8:0]        txStatus,
  input  logic              rxValid,
  input  logic [15:0]       rxLen,
  input  logic [8:0]        rxStatus,
  output logic [31:0]       rxBufAddr
);
  localparam int IDX_W = $clog2(DESC_NUM);

  engStrobe_t       strb;
  logic [31:0]      curTxStat, curRxStat;
  logic             txEn, rxEn;
  logic [IDX_W-1:0] txIdx, rxIdx, txNum;
  logic [4:0]       intSrc, intMask;

  assign txLen = curTxStat[31:16];
  assign txPad = curTxStat[PAD_BIT];
  assign txCrc = curTxStat[CRC_BIT];

  ring_sched_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .rxEn(rxEn),
    .txOwned(curTxStat[OWN_BIT]), .rxOwned(curRxStat[OWN_BIT]),
    .txDone(txDone), .rxValid(rxValid), .txReq(txReq), .strb(strb)
  );

  ring_sched_dp #(.DESC_NUM(DESC_NUM), .TX_MAX(TX_MAX), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .strb(strb),
    .txStatus(txStatus), .rxLen(rxLen), .rxStatus(rxStatus),
    .curTxStat(curTxStat), .curTxAddr(txBufAddr),
    .curRxStat(curRxStat), .curRxAddr(rxBufAddr),
    .txEn(txEn), .rxEn(rxEn), .txIdx(txIdx), .rxIdx(rxIdx), .txNum(txNum),
    .intSrc(intSrc), .intMask(intMask), .irq(irq)
  );
endmodule

// File: rtl/desc_ring_sched_chk.sv
module desc_ring_sched_chk #(
  parameter int DESC_NUM = 256,
  parameter int TX_MAX   = 128,
  parameter int IDX_W    = $clog2(DESC_NUM)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txReq,
  input logic             txDone,
  input logic             txEn,
  input logic             rxEn,
  input logic             rxValid,
  input logic [31:0]      curRxStat,
  input logic [IDX_W-1:0] txIdx,
  input logic [IDX_W-1:0] rxIdx,
  input logic [IDX_W-1:0] txNum,
  input logic [4:0]       intSrc
);
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txDone |=> txReq);
  // R6
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReq) |-> $past(txEn));
  // R5
  tx_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIdx < txNum);
  // R8
  rx_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIdx >= txNum && int'(rxIdx) < DESC_NUM);
  // R9
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxEn && !curRxStat[15] |=> intSrc[4]);
  // R11
  num_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    txNum >= 1 && int'(txNum) <= TX_MAX);
endmodule

bind desc_ring_sched desc_ring_sched_chk #(.DESC_NUM(DESC_NUM), .TX_MAX(TX_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .txReq(txReq), .txDone(txDone), .txEn(txEn),
  .rxEn(rxEn), .rxValid(rxValid), .curRxStat(curRxStat), .txIdx(txIdx),
  .rxIdx(rxIdx), .txNum(txNum), .intSrc(intSrc)
);

// File: tb/desc_ring_sched_bench.sv
module desc_ring_sched_bench;
  localparam int DN = 16;
  localparam int TM = 8;
  localparam int AW = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic irq, txReq, txPad, txCrc;
  logic [31:0] txBufAddr, rxBufAddr;
  logic [15:0] txLen;
  logic txDone = 1'b0, rxValid = 1'b0;
  logic [8:0] txStatus = '0, rxStatus = '0;
  logic [15:0] rxLen = '0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  desc_ring_sched #(.DESC_NUM(DN), .TX_MAX(TM), .ADDR_W(AW)) u_desc_ring_sched (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq), .txReq(txReq),
    .txBufAddr(txBufAddr), .txLen(txLen), .txPad(txPad), .txCrc(txCrc),
    .txDone(txDone), .txStatus(txStatus), .rxValid(rxValid), .rxLen(rxLen),
    .rxStatus(rxStatus), .rxBufAddr(rxBufAddr)
  );

  function automatic logic [AW-1:0] dstat(int i); return AW'('h400 + 8 * i); endfunction
  function automatic logic [AW-1:0] daddr(int i); return AW'('h404 + 8 * i); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); hostAddr = a; #1 d = hostRdata;
  endtask

  task automatic waitReq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk); if (txReq) seen = 1'b1;
    end
  endtask

  task automatic txFinish(logic [8:0] st);
    @(negedge clk); txDone = 1'b1; txStatus = st;
    @(negedge clk); txDone = 1'b0; txStatus = '0;
  endtask

  task automatic rxPulse(logic [15:0] len, logic [8:0] st);
    @(negedge clk); rxValid = 1'b1; rxLen = len; rxStatus = st;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(AW'('h00), d); chk("R1 mode", d, 0);
    rd(AW'('h04), d); chk("R1 source", d, 0);
    rd(AW'('h08), d); chk("R1 mask", d, 0);
    rd(AW'('h0C), d); chk("R1 txcount", d, 8);
    chk("R1 txReq/irq", {txReq, irq}, 0);
  endtask

  task automatic testTxBasic();
    logic [31:0] d; bit seen;
    wr(daddr(0), 32'h1000);
    wr(AW'('h00), 32'h3);
    wr(dstat(0), 32'h003CC800);
    waitReq(seen); chk("R2 request", seen, 1);
    chk("R2 fields", {txLen, 14'd0, txPad, txCrc}, {16'd60, 16'h0001});
    chk("R2 address", txBufAddr, 32'h1000);
    repeat (3) @(negedge clk);
    chk("R2 held", txReq, 1);
    txFinish(9'h030);
    rd(dstat(0), d); chk("R3 writeback", d, 32'h003C4830);
    rd(AW'('h04), d); chk("R4 done source", d, 32'h01);
    chk("R10 masked off", irq, 0);
    wr(AW'('h08), 32'h1F);
    #1 chk("R10 irq on", irq, 1);
    wr(AW'('h04), 32'h01);
    rd(AW'('h04), d); chk("R10 w1c", d, 0);
    chk("R10 irq off", irq, 0);
  endtask

  task automatic testTxErr();
    logic [31:0] d; bit seen;
    wr(dstat(1), 32'h003DD000);
    waitReq(seen); chk("R5 next index", txLen, 61);
    chk("R2 pad", txPad, 1);
    txFinish(9'h008);
    rd(dstat(1), d); chk("R3 error writeback", d, 32'h003D5008);
    rd(AW'('h04), d); chk("R4 error source", d, 32'h02);
    wr(AW'('h04), 32'h1F);
    wr(dstat(2), 32'h003E8000);
    waitReq(seen); chk("R2 request2", seen, 1);
    txFinish(9'h001);
    rd(dstat(2), d); chk("R3 no-irq writeback", d, 32'h003E0001);
    rd(AW'('h04), d); chk("R4 no source", d, 0);
  endtask

  task automatic testTxWrap();
    logic [31:0] d; bit seen;
    wr(dstat(4), 32'h00508000);
    wr(dstat(3), 32'h0046A000);
    waitReq(seen); chk("R5 desc3", txLen, 70);
    txFinish(9'h000);
    rd(dstat(3), d); chk("R3 wrap kept", d, 32'h00462000);
    repeat (5) @(negedge clk);
    chk("R5 no skip to 4", txReq, 0);
    wr(dstat(0), 32'h005A8000);
    waitReq(seen); chk("R5 wrap to 0", txLen, 90);
    chk("R5 wrap addr", txBufAddr, 32'h1000);
    txFinish(9'h000);
  endtask

  task automatic testTxDisable();
    bit seen;
    wr(AW'('h00), 32'h1);
    wr(dstat(1), 32'h00218000);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (txReq) seen = 1'b1; end
    chk("R6 gated", seen, 0);
    wr(AW'('h00), 32'h3);
    waitReq(seen); chk("R6 resumes", {15'd0, seen, txLen}, {16'd1, 16'd33});
    txFinish(9'h000);
  endtask

  task automatic testRx();
    logic [31:0] d;
    wr(AW'('h04), 32'h1F);
    wr(daddr(8), 32'h8800);
    wr(daddr(9), 32'h9900);
    wr(dstat(8), 32'h0000C000);
    wr(dstat(9), 32'h0000E000);
    #1 chk("R8 rx starts at N", rxBufAddr, 32'h8800);
    rxPulse(16'd100, 9'h100);
    rd(dstat(8), d); chk("R7 claim writeback", d, 32'h00644100);
    rd(AW'('h04), d); chk("R7 ok source", d, 32'h04);
    chk("R7 advance", rxBufAddr, 32'h9900);
    wr(AW'('h04), 32'h1F);
    rxPulse(16'd64, 9'h002);
    rd(dstat(9), d); chk("R7 err writeback", d, 32'h00406002);
    rd(AW'('h04), d); chk("R7 err source", d, 32'h08);
    chk("R8 wrap to N", rxBufAddr, 32'h8800);
    wr(AW'('h04), 32'h1F);
    rxPulse(16'd50, 9'h000);
    rd(AW'('h04), d); chk("R9 busy source", d, 32'h10);
    rd(dstat(8), d); chk("R9 table kept", d, 32'h00644100);
    wr(AW'('h04), 32'h1F);
    wr(AW'('h00), 32'h2);
    wr(dstat(8), 32'h0000C000);
    rxPulse(16'd77, 9'h000);
    rd(dstat(8), d); chk("R9 rx disabled", d, 32'h0000C000);
    rd(AW'('h04), d); chk("R9 rx disabled source", d, 0);
  endtask

  task automatic testClamp();
    logic [31:0] d;
    wr(daddr(5), 32'h5500);
    wr(AW'('h0C), 32'd20);
    rd(AW'('h0C), d); chk("R11 clamp high", d, 8);
    wr(AW'('h0C), 32'd0);
    rd(AW'('h0C), d); chk("R11 clamp low", d, 1);
    wr(AW'('h0C), 32'd5);
    rd(AW'('h0C), d); chk("R11 value", d, 5);
    chk("R11 rx index reset", rxBufAddr, 32'h5500);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTxBasic();
    testTxErr();
    testTxWrap();
    testTxDisable();
    testRx();
    testClamp();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule